// File: doc/BRIEF.md
# Store-Sequence Filter for Load Re-execution

This block decides, at the moment a load is about to commit, whether the value it read can be trusted or whether it must be re-executed in program order first. Stores are named by monotonically increasing sequence numbers. Each committed store records, in a small table selected by low address bits, the upper part of its address and its own sequence number. The newest store to reach an entry replaces whatever the entry held before.

A load arrives at commit with its address and the sequence number of the youngest store it is already known to be safe against. That number is the store it forwarded from, or the count of completed stores when it executed. If the table entry for the load's address holds the same address tag and a sequence number no younger than that bound, no store the load could have missed has touched the location, and the load may commit as is. If the entry is younger, holds another address, or has never been written since reset, the block cannot rule out a conflict and asks for a replay. The verdict is registered and appears one cycle after the request.

Top module: `store_seq_filter`

## Requirements
- R1: After reset `chk_valid` and `chk_replay` are 0, and every table entry is unknown, so any load checked before a store has written its entry gets `chk_replay`=1.
- R2: A load request with `ld_valid`=1 in cycle N produces `chk_valid`=1 in cycle N+1 with its verdict on `chk_replay`. Without a request in cycle N, `chk_valid` is 0 in cycle N+1. Back-to-back requests give back-to-back verdicts.
- R3: The entry index is `addr[OFF_W +: IDX_W]` (bits 8..3 by default) and the tag is `addr[ADDR_W-1 : OFF_W+IDX_W]` (bits 31..9 by default). A store with `st_valid`=1 writes its tag and `st_ssn` into the entry it selects and marks that entry known.
- R4: A load is safe (`chk_replay`=0) when its entry is known, the tags match, and the stored sequence number is less than or equal to `ld_safe_ssn`, compared unsigned. Equality counts as safe.
- R5: When the entry tag matches but the stored sequence number is greater than `ld_safe_ssn`, `chk_replay`=1.
- R6: When the entry holds a different tag, because another address with the same index wrote it, `chk_replay`=1 whatever the sequence numbers are.
- R7: When a store and a load check the same entry in the same cycle, the store is applied first and the load is judged against the store's tag and sequence number.
- R8: A later store to an entry replaces the earlier one completely, so only the most recent store's tag and sequence number decide later checks.
- R9: `chk_replay` is 0 in every cycle in which `chk_valid` is 0.
- R10: Address bits below `OFF_W` are ignored. Addresses that differ only in bits 2..0 by default share an entry and a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store commits this cycle |
| st_addr | input | ADDR_W | Address of the committing store |
| st_ssn | input | SSN_W | Sequence number of the committing store |
| ld_valid | input | 1 | A load requests a verdict this cycle |
| ld_addr | input | ADDR_W | Address of the load |
| ld_safe_ssn | input | SSN_W | Youngest store the load is known to be safe against |
| chk_valid | output | 1 | Verdict for the previous cycle's load request |
| chk_replay | output | 1 | 1: re-execute the load; 0: load may commit |

## Verification
Every verdict is due exactly one clock edge after its request. A store, however, takes effect in the same cycle for a load to the same entry, and from the following cycle for every other load. The driver changes inputs shortly after a rising edge and pushes the expected verdict into a queue at the same time. The monitor samples at the falling edge after the next rising edge and pops one expectation each time `chk_valid` is high. An idle cycle that still shows a verdict, or a verdict that never arrives, is therefore reported as a miscompare. Expected verdicts come from a separate table model in the bench that applies a same-cycle store before the lookup.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
    typedef enum logic {
        VERDICT_SAFE   = 1'b0,
        VERDICT_REPLAY = 1'b1
    } verdict_e;
endpackage

// File: rtl/ssf_table.sv
module ssf_table #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 23,
    parameter int SSN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [SSN_W-1:0] wr_ssn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_known,
    output logic [TAG_W-1:0] rd_tag,
    output logic [SSN_W-1:0] rd_ssn
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             known;
        logic [TAG_W-1:0] tag;
        logic [SSN_W-1:0] ssn;
    } slot_t;

    slot_t slot_d [DEPTH];
    slot_t slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx] = '{known: 1'b1, tag: wr_tag, ssn: wr_ssn};
        end
    end

    // Reading the next-state copy lets a same-cycle store win over the lookup.
    always_comb begin
        rd_known = slot_d[rd_idx].known;
        rd_tag   = slot_d[rd_idx].tag;
        rd_ssn   = slot_d[rd_idx].ssn;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    // R3: a committed store leaves its entry known and holding its fields
    assert_store_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot_q[$past(wr_idx)].known
                   && slot_q[$past(wr_idx)].tag == $past(wr_tag)
                   && slot_q[$past(wr_idx)].ssn == $past(wr_ssn)));
endmodule

// File: rtl/ssf_judge.sv
module ssf_judge
    import ssf_pkg::*;
#(
    parameter int TAG_W = 23,
    parameter int SSN_W = 16
) (
    input  logic             ent_known,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [SSN_W-1:0] ent_ssn,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic [SSN_W-1:0] ld_bound,
    output verdict_e         verdict
);
    logic tag_hit;
    logic window_clear;

    always_comb begin
        tag_hit      = ent_known && (ent_tag == ld_tag);
        window_clear = (ent_ssn <= ld_bound);
        verdict      = (tag_hit && window_clear) ? VERDICT_SAFE : VERDICT_REPLAY;
    end
endmodule

// File: rtl/store_seq_filter.sv
module store_seq_filter
    import ssf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 3,
    parameter int IDX_W  = 6,
    parameter int SSN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SSN_W-1:0]  st_ssn,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SSN_W-1:0]  ld_safe_ssn,
    output logic              chk_valid,
    output logic              chk_replay
);
    localparam int TAG_LO = OFF_W + IDX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    typedef struct packed {
        logic valid;
        logic replay;
    } result_t;

    logic [IDX_W-1:0] st_idx, ld_idx;
    logic [TAG_W-1:0] st_tag, ld_tag;
    logic             unused_offset_bits;

    logic             ent_known;
    logic [TAG_W-1:0] ent_tag;
    logic [SSN_W-1:0] ent_ssn;
    verdict_e         verdict;

    result_t res_d, res_q;

    always_comb begin
        st_idx = st_addr[OFF_W +: IDX_W];
        ld_idx = ld_addr[OFF_W +: IDX_W];
        st_tag = st_addr[ADDR_W-1:TAG_LO];
        ld_tag = ld_addr[ADDR_W-1:TAG_LO];
        unused_offset_bits = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};
    end

    ssf_table #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .SSN_W (SSN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_valid),
        .wr_idx   (st_idx),
        .wr_tag   (st_tag),
        .wr_ssn   (st_ssn),
        .rd_idx   (ld_idx),
        .rd_known (ent_known),
        .rd_tag   (ent_tag),
        .rd_ssn   (ent_ssn)
    );

    ssf_judge #(
        .TAG_W (TAG_W),
        .SSN_W (SSN_W)
    ) u_judge (
        .ent_known (ent_known),
        .ent_tag   (ent_tag),
        .ent_ssn   (ent_ssn),
        .ld_tag    (ld_tag),
        .ld_bound  (ld_safe_ssn),
        .verdict   (verdict)
    );

    always_comb begin
        res_d.valid  = ld_valid;
        res_d.replay = ld_valid && (verdict == VERDICT_REPLAY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign chk_valid  = res_q.valid;
    assign chk_replay = res_q.replay;

    // R2: one verdict per request, exactly one cycle later
    assert_verdict_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> chk_valid);
    assert_no_stray_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !chk_valid);
    // R9: no replay flag without a verdict
    assert_quiet_replay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_replay);
    // R7: same-cycle matching store with an old enough number makes the load safe
    assert_bypass_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ld_valid && st_idx == ld_idx && st_tag == ld_tag
         && st_ssn <= ld_safe_ssn) |=> !chk_replay);
    // R7: same-cycle store that is too young forces a replay
    assert_bypass_young_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ld_valid && st_idx == ld_idx && st_ssn > ld_safe_ssn)
        |=> chk_replay);
    // R6: same-cycle alias store forces a replay
    assert_bypass_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && ld_valid && st_idx == ld_idx && st_tag != ld_tag)
        |=> chk_replay);
endmodule

// File: tb/store_seq_filter_bench.sv
module store_seq_filter_bench;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 3;
    localparam int IDX_W  = 6;
    localparam int SSN_W  = 16;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int TLO    = OFF_W + IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [SSN_W-1:0]  st_ssn = '0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [SSN_W-1:0]  ld_safe_ssn = '0;
    logic              chk_valid, chk_replay;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_q [$];
    string req_q [$];

    bit                   m_known [DEPTH];
    logic [ADDR_W-TLO-1:0] m_tag  [DEPTH];
    logic [SSN_W-1:0]     m_ssn   [DEPTH];

    always #5 clk = ~clk;

    store_seq_filter #(
        .ADDR_W (ADDR_W), .OFF_W (OFF_W), .IDX_W (IDX_W), .SSN_W (SSN_W)
    ) u_store_seq_filter (
        .clk (clk), .rst_n (rst_n),
        .st_valid (st_valid), .st_addr (st_addr), .st_ssn (st_ssn),
        .ld_valid (ld_valid), .ld_addr (ld_addr), .ld_safe_ssn (ld_safe_ssn),
        .chk_valid (chk_valid), .chk_replay (chk_replay)
    );

    task automatic step(input bit sv, input logic [ADDR_W-1:0] sa, input logic [SSN_W-1:0] ss,
                        input bit lv, input logic [ADDR_W-1:0] la, input logic [SSN_W-1:0] ls,
                        input string req);
        int si, li;
        bit rep;
        @(posedge clk);
        #2;
        st_valid = sv; st_addr = sa; st_ssn = ss;
        ld_valid = lv; ld_addr = la; ld_safe_ssn = ls;
        si = int'(sa[OFF_W +: IDX_W]);
        li = int'(la[OFF_W +: IDX_W]);
        if (sv) begin
            m_known[si] = 1'b1;
            m_tag[si]   = sa[ADDR_W-1:TLO];
            m_ssn[si]   = ss;
        end
        if (lv) begin
            rep = !(m_known[li] && m_tag[li] == la[ADDR_W-1:TLO] && m_ssn[li] <= ls);
            exp_q.push_back(rep);
            req_q.push_back(req);
        end
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, '0, '0, "");
    endtask

    task automatic store(input logic [ADDR_W-1:0] a, input logic [SSN_W-1:0] s);
        step(1'b1, a, s, 1'b0, '0, '0, "");
    endtask

    task automatic load(input logic [ADDR_W-1:0] a, input logic [SSN_W-1:0] s, input string req);
        step(1'b0, '0, '0, 1'b1, a, s, req);
    endtask

    // monitor: pops one expectation per verdict
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if (chk_valid) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R2: verdict with no request, got valid=1 expected valid=0");
                    end else begin
                        bit e;
                        string r;
                        e = exp_q.pop_front();
                        r = req_q.pop_front();
                        if (chk_replay !== e) begin
                            fails++;
                            $display("FAIL %s: replay=%0b expected %0b", r, chk_replay, e);
                        end
                    end
                end else begin
                    checks++;
                    if (chk_replay !== 1'b0) begin
                        fails++;
                        $display("FAIL R9: replay=%0b with no verdict, expected 0", chk_replay);
                    end
                end
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a, b, c, d;
        for (int i = 0; i < DEPTH; i++) begin
            m_known[i] = 1'b0; m_tag[i] = '0; m_ssn[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (chk_valid !== 1'b0 || chk_replay !== 1'b0) begin
            fails++;
            $display("FAIL R1: valid=%0b replay=%0b in reset, expected 0 0", chk_valid, chk_replay);
        end
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1: empty table always asks for replay
        load(32'h0000_0100, 16'hFFFF, "R1");
        load(32'h0000_0000, 16'h0000, "R1");
        idle();

        // R3/R4/R5: fill, then bound equal, below, above
        a = 32'h0000_1000;
        store(a, 16'd5);
        load(a, 16'd5, "R4");
        load(a, 16'd4, "R5");
        load(a, 16'd9, "R4");
        // R10: low offset bits ignored
        load(a + 32'd3, 16'd5, "R10");
        load(a + 32'd7, 16'd4, "R10");

        // R6: alias with same index, other tag
        b = a + (32'd1 << TLO);
        load(b, 16'hFFFF, "R6");
        store(b, 16'd7);
        load(a, 16'd100, "R6");
        load(b, 16'd7, "R3");

        // R8: most recent store decides
        store(a, 16'd10);
        store(a, 16'd12);
        load(a, 16'd11, "R8");
        load(a, 16'd12, "R8");
        store(a, 16'd3);
        load(a, 16'd4, "R8");

        // R7: same-cycle store applied before the lookup
        c = 32'h0000_2040;
        d = c + (32'd5 << TLO);
        step(1'b1, c, 16'd20, 1'b1, c, 16'd20, "R7");
        step(1'b1, c, 16'd30, 1'b1, c, 16'd25, "R7");
        step(1'b1, d, 16'd1, 1'b1, c, 16'd99, "R7");
        load(d, 16'd1, "R7");
        idle();
        idle();

        // R3/R2: sweep every entry, back-to-back loads
        for (int i = 0; i < DEPTH; i++) begin
            store(32'h00AB_0000 | (32'(i) << OFF_W), 16'(i + 1));
        end
        for (int i = 0; i < DEPTH; i++) begin
            load(32'h00AB_0000 | (32'(i) << OFF_W), 16'(i + 1), "R3");
            load(32'h00AB_0000 | (32'(i) << OFF_W), 16'(i), "R5");
        end
        idle();
        idle();
        idle();
        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d verdicts missing, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule